// File: doc/BRIEF.md
# Output Port with Chip-Select Override

An output-only port of `WIDTH` pins with no direction control. Each pin shows one of two sources. The first is a bit of a stored output data register. The second is an active-low chip-select strobe that an external address decoder produces. A per-bit override register picks the source for each pin. Both registers sit behind a small write/read register interface that uses a one-bit register address.

When the override bit is set, pin x follows chip-select x directly. When it is clear, pin x follows data bit x. Reset fills the data register with ones and clears the override register, with one exception. The top override bit takes the value of a bus-control input, which is sampled only while reset is held. With that input high, the top chip-select therefore reaches the top pin from the first cycle after reset.

Top module: `cs_out_port`

## Requirements
- R1: While and after reset, the data register (address 0) reads all ones.
- R2: While and after reset, the override register (address 1) reads zero in bits WIDTH-2..0, and its top bit equals `bus_ctl7_i` as sampled during reset.
- R3: A change of `bus_ctl7_i` after reset is released leaves the override register unchanged.
- R4: When override bit x is 1, `pin_o[x]` equals `cs_ni[x]`, with no register delay.
- R5: When override bit x is 0, `pin_o[x]` equals data register bit x.
- R6: With `wr_en_i` high at a rising clock edge, `wdata_i` is stored into the data register when `addr_i`=0 and into the override register when `addr_i`=1. The new value is visible at the outputs after that edge.
- R7: `rdata_o` combinationally returns the stored register selected by `addr_i` (0 data, 1 override). A data read returns the stored value, not the pin level.
- R8: After a reset with `bus_ctl7_i`=1 and every `cs_ni` bit high, every pin is high.
- R9: With `wr_en_i` low, changes on `wdata_i` and `addr_i` alter neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 data, 1 override |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data of the selected register |
| bus_ctl7_i | input | 1 | Bus-control bit 7, gives the reset value of the top override bit |
| cs_ni | input | WIDTH | Active-low chip-select strobes from the decoder |
| pin_o | output | WIDTH | Port pins |

## Verification
A wrong stored bit in either register shows on `rdata_o` in the same cycle that register is addressed. A corrupt override bit also shows on its pin as soon as that chip-select differs from the matching data bit. The bench models both registers cycle by cycle and compares pins and read data on every clock. It drives chip-select patterns that disagree with the data on purpose, so that a wrong source choice cannot stay hidden. A second reset with the bus-control bit low checks that the top override bit is sampled and not fixed.

// File: rtl/cs_port_pkg.sv
package cs_port_pkg;
  typedef enum logic {
    REG_DATA = 1'b0,
    REG_CSEN = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cs_port_regs.sv
module cs_port_regs
  import cs_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             bus_ctl7_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] csen_o,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int TOP = WIDTH - 1;

  reg_sel_e   sel;
  logic [WIDTH-1:0] data_q, csen_q;
  logic             wr_data, wr_csen;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_data = wr_en_i && (sel == REG_DATA);
  assign wr_csen = wr_en_i && (sel == REG_CSEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '1;
    else if (wr_data) data_q <= wdata_i;
  end

  // top enable bit follows bus-control bit 7 only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csen_q      <= '0;
      csen_q[TOP] <= bus_ctl7_i;
    end else if (wr_csen) begin
      csen_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel)
      REG_CSEN: rdata_o = csen_q;
      default:  rdata_o = data_q;
    endcase
  end

  assign data_o = data_q;
  assign csen_o = csen_q;
endmodule

// File: rtl/cs_port_mux.sv
module cs_port_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] csen_i,
  input  logic [WIDTH-1:0] cs_ni,
  output logic [WIDTH-1:0] pin_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pin_o[i] = csen_i[i] ? cs_ni[i] : data_i[i];
  end
endmodule

// File: rtl/cs_out_port.sv
module cs_out_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             bus_ctl7_i,
  input  logic [WIDTH-1:0] cs_ni,
  output logic [WIDTH-1:0] pin_o
);
  logic [WIDTH-1:0] data_q, csen_q;

  cs_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .bus_ctl7_i (bus_ctl7_i),
    .data_o     (data_q),
    .csen_o     (csen_q),
    .rdata_o    (rdata_o)
  );

  cs_port_mux #(.WIDTH(WIDTH)) u_mux (
    .data_i (data_q),
    .csen_i (csen_q),
    .cs_ni  (cs_ni),
    .pin_o  (pin_o)
  );
endmodule

// File: rtl/cs_out_port_chk.sv
module cs_out_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             addr_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic             bus_ctl7_i,
  input logic [WIDTH-1:0] cs_ni,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] data_q,
  input logic [WIDTH-1:0] csen_q
);
  a_r1_data_reset: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> data_q == '1);

  a_r2_csen_reset: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> csen_q == {$past(bus_ctl7_i), {(WIDTH-1){1'b0}}});

  a_r4_cs_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o ^ cs_ni) & csen_q) == '0);

  a_r5_data_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o ^ data_q) & ~csen_q) == '0);

  a_r6_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i) |=> data_q == $past(wdata_i));

  a_r6_csen_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i) |=> csen_q == $past(wdata_i));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(data_q) && $stable(csen_q)));
endmodule

bind cs_out_port cs_out_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .bus_ctl7_i (bus_ctl7_i),
  .cs_ni      (cs_ni),
  .pin_o      (pin_o),
  .data_q     (data_q),
  .csen_q     (csen_q)
);

// File: tb/cs_out_port_bench.sv
module cs_out_port_bench;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic         addr_i = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic         bus_ctl7_i = 1'b1;
  logic [W-1:0] cs_ni = '1;
  logic [W-1:0] pin_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R2";

  logic [W-1:0] m_data = '1;
  logic [W-1:0] m_csen = '0;

  always #5 clk_i = ~clk_i;

  cs_out_port #(.WIDTH(W)) u_cs_out_port (.*);

  // reference model: updated from bench inputs at each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_data = '1;
      m_csen = '0;
      m_csen[W-1] = bus_ctl7_i;
    end else if (wr_en_i) begin
      if (addr_i) m_csen = wdata_i;
      else        m_data = wdata_i;
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_pins();
    logic [W-1:0] p;
    for (int i = 0; i < W; i++) p[i] = m_csen[i] ? cs_ni[i] : m_data[i];
    return p;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(cur_req, "pins", pin_o, exp_pins());
      chk("R7", "rdata", rdata_o, addr_i ? m_csen : m_data);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic wr(logic a, logic [W-1:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic a, logic [W-1:0] exp);
    addr_i = a;
    #1;
    chk(req, "read", rdata_o, exp);
  endtask

  initial begin
    cyc(3);
    rd_chk("R1", 1'b0, 8'hFF);
    rd_chk("R2", 1'b1, 8'h80);
    rst_ni = 1'b1;
    cyc();
    cur_req = "R8";
    chk("R8", "idle pins", pin_o, 8'hFF);
    cyc(2);

    cur_req = "R3";
    bus_ctl7_i = 1'b0;
    cyc(3);
    rd_chk("R3", 1'b1, 8'h80);
    bus_ctl7_i = 1'b1;

    cur_req = "R4";
    cs_ni = 8'h7F;
    #1;
    chk("R4", "cs7 low on pin", pin_o, 8'h7F);
    cs_ni = 8'h00;
    #1;
    chk("R4", "only pin7 follows cs", pin_o, 8'h7F);
    cs_ni = '1;

    cur_req = "R6";
    wr(1'b0, 8'h5A);
    rd_chk("R6", 1'b0, 8'h5A);
    cur_req = "R5";
    #1;
    chk("R5", "data on pins", pin_o, 8'hDA);
    wr(1'b1, 8'h0F);
    rd_chk("R6", 1'b1, 8'h0F);
    cs_ni = 8'hF5;
    #1;
    chk("R4", "low nibble from cs", pin_o, 8'h55);
    rd_chk("R7", 1'b0, 8'h5A);

    cur_req = "R9";
    wdata_i = 8'hC3; addr_i = 1'b0;
    cyc(2);
    addr_i = 1'b1;
    cyc(2);
    rd_chk("R9", 1'b1, 8'h0F);
    rd_chk("R9", 1'b0, 8'h5A);

    cur_req = "R5";
    for (int k = 0; k < 300; k++) begin
      wr_en_i = 1'($urandom_range(0, 1));
      addr_i = 1'($urandom_range(0, 1));
      wdata_i = W'($urandom);
      cs_ni = W'($urandom);
      bus_ctl7_i = 1'($urandom_range(0, 1));
      cyc();
    end
    wr_en_i = 1'b0;

    bus_ctl7_i = 1'b0;
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc();
    rd_chk("R2", 1'b1, 8'h00);
    rd_chk("R1", 1'b0, 8'hFF);
    cs_ni = 8'h00;
    #1;
    chk("R5", "no override after low bus-ctl", pin_o, 8'hFF);
    cyc(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule